// File: doc/BRIEF.md
# CEC Transmit Message Sequencer

This block sits between a host register interface and a CEC bit engine and turns byte writes into a transmitted message. The host writes one byte at a time into a single data register and sets two control bits: a start bit that begins a message and a last-byte bit that marks the end of the message. The sequencer moves each byte into a holding slot together with its last-byte marker. It offers the slot to the bit engine through a valid/ready handshake and waits for the engine to report how the byte went.

The block raises a set of sticky status flags. These tell the host that the next byte is needed, that the message completed, that a needed byte was missing, or that the engine reported a missing acknowledge, a line held low, or lost arbitration. Each flag is cleared by writing a one to its bit. A mask of enable bits selects which flags drive the single interrupt output. An enable input gates all host writes, and dropping it returns the sequencer to idle.

Top module: `cec_tx_seq`

## Requirements
- R1: One cycle after a start command is registered while the data register holds a byte, `eng_valid` rises and `eng_byte` carries that byte.
- R2: The last-byte marker is sampled when a byte moves from the data register to the engine. `eng_last` is 1 only if the last-byte bit was set by then, so a one-byte message needs that bit set no later than the start bit.
- R3: Flag bit 0 (byte request) is set whenever a byte without the last-byte marker is moved to the engine. It is not set for the final byte.
- R4: Flag bit 2 (underrun) is set when the sequencer needs a byte (at start, or after a non-final byte completes) and the data register is empty. The message then ends and `eng_valid` stays low.
- R5: When the engine reports result 0 (success) for the final byte, flag bit 1 (end of transmission) is set. The start and last-byte bits clear themselves when the final byte is accepted, so no further byte is sent.
- R6: Engine result 1 sets flag bit 3 (no acknowledge), result 2 sets flag bit 4 (line error), and result 3 sets flag bit 5 (arbitration lost). Any of these ends the message without setting bit 1.
- R7: Writing 1 to a bit of `flag_clr` clears that flag. Writing 0 leaves it unchanged. A flag set in the same cycle stays set.
- R8: `irq` is high exactly while some flag is set and its bit in `irq_en` is also set.
- R9: While `enable` is low, data writes and control writes are ignored. Dropping `enable` forces the sequencer to idle with `eng_valid` low and both control bits cleared.
- R10: While `eng_valid` is high and `eng_ready` is low, the offered byte and marker stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low gates host writes and forces idle |
| data_we | input | 1 | Write strobe for the transmit data register |
| data_in | input | 8 | Byte to load into the data register |
| ctrl_we | input | 1 | Write strobe for the control bits |
| ctrl_som | input | 1 | Sets the start-of-message bit when written as 1 |
| ctrl_eom | input | 1 | Sets the last-byte bit when written as 1 |
| flag_clr | input | 6 | Write-one-to-clear mask for the flags |
| irq_en | input | 6 | Per-flag interrupt enable |
| eng_valid | output | 1 | A byte is offered to the bit engine |
| eng_byte | output | 8 | Byte offered to the bit engine |
| eng_last | output | 1 | Offered byte is the final one of the message |
| eng_ready | input | 1 | Bit engine accepts the offered byte |
| eng_done | input | 1 | Bit engine reports the outcome of the accepted byte |
| eng_res | input | 2 | Outcome: 0 ok, 1 no acknowledge, 2 line error, 3 arbitration lost |
| flags | output | 6 | Sticky status flags |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the underrun in the middle of a message. It needs a non-final byte to be accepted and completed while the host has not yet refilled the data register. The bench gets there by starting a message with one loaded byte and no last-byte bit, then completing it with a success result and writing nothing in between. A related case is a data write that lands in the same window as a byte hand-over. The bench covers it by writing the next byte while the previous one is still in flight, so the model must track a register that is emptied and refilled around the completion. The model runs alongside the design and is compared on every cycle, so disable-while-sending and lingering start bits are checked as well.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;
    localparam int BYTE_W = 8;
    localparam int NFLAG  = 6;
    localparam int RES_W  = 2;

    localparam int F_BREQ = 0;
    localparam int F_END  = 1;
    localparam int F_UDR  = 2;
    localparam int F_NACK = 3;
    localparam int F_LINE = 4;
    localparam int F_ARB  = 5;

    localparam logic [NFLAG-1:0] ERR_MASK =
        NFLAG'((1 << F_UDR) | (1 << F_NACK) | (1 << F_LINE) | (1 << F_ARB));

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_t;

    typedef enum logic [RES_W-1:0] {
        RES_OK   = 2'd0,
        RES_NACK = 2'd1,
        RES_LINE = 2'd2,
        RES_ARB  = 2'd3
    } eng_res_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              last;
    } tx_slot_t;

    function automatic logic [NFLAG-1:0] res_flag(eng_res_t r);
        logic [NFLAG-1:0] f;
        f = '0;
        case (r)
            RES_NACK: f[F_NACK] = 1'b1;
            RES_LINE: f[F_LINE] = 1'b1;
            RES_ARB:  f[F_ARB]  = 1'b1;
            default:  f = '0;
        endcase
        return f;
    endfunction
endpackage

// File: rtl/cec_tx_databuf.sv
module cec_tx_databuf
    import cec_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              take,
    output logic [BYTE_W-1:0] held_byte,
    output logic              held_full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_byte <= '0;
            held_full <= 1'b0;
        end else if (wr_en) begin
            held_byte <= wr_byte;
            held_full <= 1'b1;
        end else if (take) begin
            held_full <= 1'b0;
        end
    end

    // R4: the sequencer only consumes a byte that is present
    assert_take_full_R4: assert property (@(posedge clk) disable iff (rst)
        take |-> held_full);
endmodule

// File: rtl/cec_tx_fsm.sv
module cec_tx_fsm
    import cec_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              ctrl_we,
    input  logic              ctrl_som,
    input  logic              ctrl_eom,
    input  logic              buf_full,
    input  logic [BYTE_W-1:0] buf_byte,
    output logic              take,
    output logic              eng_valid,
    output logic [BYTE_W-1:0] eng_byte,
    output logic              eng_last,
    input  logic              eng_ready,
    input  logic              eng_done,
    input  logic [RES_W-1:0]  eng_res,
    output logic [NFLAG-1:0]  flag_set
);
    seq_state_t state_q, state_n;
    tx_slot_t   slot_q;
    logic       som_q, eom_q;
    logic       load_c, drop_c;
    eng_res_t   res_c;

    assign res_c = eng_res_t'(eng_res);

    always_comb begin
        state_n  = state_q;
        take     = 1'b0;
        load_c   = 1'b0;
        drop_c   = 1'b0;
        flag_set = '0;
        if (!enable) begin
            state_n = ST_IDLE;
            drop_c  = 1'b1;
        end else begin
            case (state_q)
                ST_IDLE: if (som_q) begin
                    if (buf_full) begin
                        take    = 1'b1;
                        load_c  = 1'b1;
                        state_n = ST_SEND;
                        flag_set[F_BREQ] = !eom_q;
                    end else begin
                        flag_set[F_UDR] = 1'b1;
                        drop_c = 1'b1;
                    end
                end
                ST_SEND: if (eng_ready) begin
                    state_n = ST_WAIT;
                    drop_c  = slot_q.last;
                end
                ST_WAIT: if (eng_done) begin
                    state_n = ST_IDLE;
                    if (res_c != RES_OK) begin
                        flag_set = res_flag(res_c);
                        drop_c   = 1'b1;
                    end else if (slot_q.last) begin
                        flag_set[F_END] = 1'b1;
                    end else if (buf_full) begin
                        take    = 1'b1;
                        load_c  = 1'b1;
                        state_n = ST_SEND;
                        flag_set[F_BREQ] = !eom_q;
                    end else begin
                        flag_set[F_UDR] = 1'b1;
                        drop_c = 1'b1;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            som_q   <= 1'b0;
            eom_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            if (load_c) slot_q <= '{data: buf_byte, last: eom_q};
            som_q <= enable && ((som_q && !drop_c) || (ctrl_we && ctrl_som));
            eom_q <= enable && ((eom_q && !drop_c) || (ctrl_we && ctrl_eom));
        end
    end

    assign eng_valid = (state_q == ST_SEND);
    assign eng_byte  = slot_q.data;
    assign eng_last  = slot_q.last;

    // R10: an offer is held until it is accepted
    assert_hold_offer_R10: assert property (@(posedge clk) disable iff (rst)
        (eng_valid && !eng_ready && enable) |=>
        (!enable || (eng_valid && $stable(eng_byte) && $stable(eng_last))));
    // R9: disabling forces idle
    assert_idle_off_R9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !eng_valid);
    // R1: a consumed byte is offered next cycle
    assert_offer_after_take_R1: assert property (@(posedge clk) disable iff (rst)
        (take && enable) |=> (!enable || eng_valid));
    // R5/R6: completion never coincides with an error
    assert_end_clean_R5: assert property (@(posedge clk) disable iff (rst)
        flag_set[F_END] |-> ((flag_set & ERR_MASK) == '0));
endmodule

// File: rtl/cec_tx_flags.sv
module cec_tx_flags
    import cec_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] set,
    input  logic [NFLAG-1:0] clr,
    input  logic [NFLAG-1:0] irq_en,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);
    logic [NFLAG-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr) | set;
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & irq_en);

    // R7: a cleared bit with no new event is low afterwards
    assert_w1c_R7: assert property (@(posedge clk) disable iff (rst)
        ((clr & ~set) != '0) |=> ((flags & $past(clr & ~set)) == '0));
    // R7: no clear and no event leaves the flags unchanged
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        ((set == '0) && (clr == '0)) |=> $stable(flags));
    // R8: nothing pending means no interrupt
    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (flags == '0) |-> !irq);
endmodule

// File: rtl/cec_tx_seq.sv
module cec_tx_seq
    import cec_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              data_we,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              ctrl_we,
    input  logic              ctrl_som,
    input  logic              ctrl_eom,
    input  logic [NFLAG-1:0]  flag_clr,
    input  logic [NFLAG-1:0]  irq_en,
    output logic              eng_valid,
    output logic [BYTE_W-1:0] eng_byte,
    output logic              eng_last,
    input  logic              eng_ready,
    input  logic              eng_done,
    input  logic [RES_W-1:0]  eng_res,
    output logic [NFLAG-1:0]  flags,
    output logic              irq
);
    logic              take;
    logic              buf_full;
    logic [BYTE_W-1:0] buf_byte;
    logic [NFLAG-1:0]  flag_set;

    cec_tx_databuf u_buf (
        .clk(clk), .rst(rst),
        .wr_en(enable && data_we), .wr_byte(data_in),
        .take(take), .held_byte(buf_byte), .held_full(buf_full)
    );

    cec_tx_fsm u_fsm (
        .clk(clk), .rst(rst), .enable(enable),
        .ctrl_we(ctrl_we), .ctrl_som(ctrl_som), .ctrl_eom(ctrl_eom),
        .buf_full(buf_full), .buf_byte(buf_byte), .take(take),
        .eng_valid(eng_valid), .eng_byte(eng_byte), .eng_last(eng_last),
        .eng_ready(eng_ready), .eng_done(eng_done), .eng_res(eng_res),
        .flag_set(flag_set)
    );

    cec_tx_flags u_flags (
        .clk(clk), .rst(rst), .set(flag_set), .clr(flag_clr),
        .irq_en(irq_en), .flags(flags), .irq(irq)
    );
endmodule

// File: tb/cec_tx_seq_tb.sv
`timescale 1ns/1ps
module cec_tx_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b1;
    logic       data_we = 1'b0;
    logic [7:0] data_in = '0;
    logic       ctrl_we = 1'b0, ctrl_som = 1'b0, ctrl_eom = 1'b0;
    logic [5:0] flag_clr = '0, irq_en = '0;
    logic       eng_ready = 1'b0, eng_done = 1'b0;
    logic [1:0] eng_res = '0;
    logic       eng_valid, eng_last, irq;
    logic [7:0] eng_byte;
    logic [5:0] flags;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    cec_tx_seq dut_i (
        .clk(clk), .rst(rst), .enable(enable), .data_we(data_we), .data_in(data_in),
        .ctrl_we(ctrl_we), .ctrl_som(ctrl_som), .ctrl_eom(ctrl_eom),
        .flag_clr(flag_clr), .irq_en(irq_en), .eng_valid(eng_valid),
        .eng_byte(eng_byte), .eng_last(eng_last), .eng_ready(eng_ready),
        .eng_done(eng_done), .eng_res(eng_res), .flags(flags), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: message position, register occupancy, flags
    int       m_st;
    bit       m_som, m_eom, m_full, m_hl;
    bit [7:0] m_data, m_hd;
    bit [5:0] m_flags;

    always @(posedge clk) begin
        int nst; bit tk, ld, drop; bit [5:0] ev;
        if (rst) begin
            m_st = 0; m_som = 0; m_eom = 0; m_full = 0; m_hl = 0;
            m_data = 0; m_hd = 0; m_flags = 0;
        end else begin
            nst = m_st; tk = 0; ld = 0; drop = 0; ev = 0;
            if (!enable) begin
                nst = 0; drop = 1;
            end else if (m_st == 0 && m_som) begin
                if (m_full) begin tk = 1; ld = 1; nst = 1; ev[0] = !m_eom; end
                else begin ev[2] = 1; drop = 1; end
            end else if (m_st == 1 && eng_ready) begin
                nst = 2; drop = m_hl;
            end else if (m_st == 2 && eng_done) begin
                nst = 0;
                if (eng_res != 0) begin ev[int'(eng_res) + 2] = 1; drop = 1; end
                else if (m_hl) ev[1] = 1;
                else if (m_full) begin tk = 1; ld = 1; nst = 1; ev[0] = !m_eom; end
                else begin ev[2] = 1; drop = 1; end
            end
            if (ld) begin m_hd = m_data; m_hl = m_eom; end
            if (enable && data_we) begin m_data = data_in; m_full = 1; end
            else if (tk) m_full = 0;
            m_flags = (m_flags & ~flag_clr) | ev;
            m_som = enable && ((m_som && !drop) || (ctrl_we && ctrl_som));
            m_eom = enable && ((m_eom && !drop) || (ctrl_we && ctrl_eom));
            m_st = nst;
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R10 eng_valid vs model", eng_valid, m_st == 1);
            if (eng_valid) begin
                chk("R1 eng_byte vs model", eng_byte, m_hd);
                chk("R2 eng_last vs model", eng_last, m_hl);
            end
            chk("R7 flags vs model", flags, m_flags);
            chk("R8 irq vs model", irq, |(m_flags & irq_en));
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask
    task automatic wr(input logic [7:0] b);
        data_we = 1; data_in = b; tick(); data_we = 0;
    endtask
    task automatic ctrl(input logic s, input logic e);
        ctrl_we = 1; ctrl_som = s; ctrl_eom = e; tick();
        ctrl_we = 0; ctrl_som = 0; ctrl_eom = 0;
    endtask
    task automatic clrf(input logic [5:0] m);
        flag_clr = m; tick(); flag_clr = 0;
    endtask
    task automatic wait_offer();
        for (int i = 0; i < 20 && !eng_valid; i++) tick();
    endtask
    task automatic accept();
        wait_offer(); eng_ready = 1; tick(); eng_ready = 0;
    endtask
    task automatic finish(input logic [1:0] r);
        eng_done = 1; eng_res = r; tick(); eng_done = 0; eng_res = 0;
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(); tick(); rst = 0; tick();
        chk("R7 reset flags", flags, 0);
        chk("R10 reset eng_valid", eng_valid, 0);
        chk("R8 reset irq", irq, 0);

        // one-byte message, last-byte bit given with start
        wr(8'hA5); ctrl(1, 1); wait_offer();
        chk("R1 single byte", eng_byte, 8'hA5);
        chk("R2 single byte marked last", eng_last, 1);
        chk("R3 no request for final byte", flags[0], 0);
        accept(); finish(0);
        chk("R5 end flag", flags[1], 1);
        clrf(6'h3f);

        // three-byte message with a stalled offer
        wr(8'h11); ctrl(1, 0); wait_offer();
        chk("R1 first byte", eng_byte, 8'h11);
        chk("R2 first byte not last", eng_last, 0);
        chk("R3 request after first byte", flags[0], 1);
        tick(); tick(); tick();
        chk("R10 held valid", eng_valid, 1);
        chk("R10 held byte", eng_byte, 8'h11);
        accept(); clrf(6'h01); wr(8'h22); finish(0);
        chk("R1 second byte", eng_byte, 8'h22);
        chk("R3 request after second byte", flags[0], 1);
        accept(); wr(8'h33); ctrl(0, 1); clrf(6'h01); finish(0);
        chk("R2 third byte last", eng_last, 1);
        chk("R3 no request for last", flags[0], 0);
        accept(); finish(0);
        chk("R5 end after three", flags[1], 1);
        tick(); tick(); tick(); tick();
        chk("R5 start bit self-cleared", eng_valid, 0);
        chk("R5 no stray underrun", flags[2], 0);
        clrf(6'h3f);

        // underrun at start
        ctrl(1, 0); tick();
        chk("R4 underrun at start", flags[2], 1);
        chk("R4 no offer", eng_valid, 0);
        clrf(6'h3f);

        // underrun mid-message
        wr(8'h44); ctrl(1, 0); accept(); finish(0);
        chk("R4 mid underrun", flags[2], 1);
        chk("R4 no end flag", flags[1], 0);
        chk("R4 idle after underrun", eng_valid, 0);
        clrf(6'h3f);

        // engine errors
        for (int r = 1; r <= 3; r++) begin
            wr(8'h50 + 8'(r)); ctrl(1, 0); accept(); finish(2'(r));
            chk("R6 error flag", flags[r + 2], 1);
            chk("R6 no end on error", flags[1], 0);
            chk("R6 idle on error", eng_valid, 0);
            if (r < 3) clrf(6'h3f);
        end

        // write-one-to-clear
        chk("R7 preset pattern", flags, 6'h21);
        clrf(6'h00);
        chk("R7 zero write keeps", flags, 6'h21);
        clrf(6'h20);
        chk("R7 single bit cleared", flags, 6'h01);
        clrf(6'h3f);
        chk("R7 all cleared", flags, 0);

        // interrupt masking
        irq_en = 6'b000010;
        ctrl(1, 0); tick();
        chk("R8 masked flag no irq", irq, 0);
        wr(8'h66); ctrl(1, 1); accept(); finish(0);
        chk("R8 enabled flag irq", irq, 1);
        clrf(6'h02);
        chk("R8 irq drops on clear", irq, 0);
        irq_en = 0; clrf(6'h3f);

        // disabled writes ignored
        enable = 0; wr(8'h77); ctrl(1, 1); tick(); tick();
        enable = 1; tick(); tick(); tick();
        chk("R9 no start while disabled", eng_valid, 0);
        chk("R9 no flags while disabled", flags, 0);
        ctrl(1, 0); tick();
        chk("R9 data write ignored", flags[2], 1);
        clrf(6'h3f);

        // disable mid-message
        wr(8'h88); ctrl(1, 0); wait_offer();
        chk("R9 offer before disable", eng_valid, 1);
        enable = 0; tick();
        chk("R9 forced idle", eng_valid, 0);
        enable = 1; tick(); tick(); tick();
        chk("R9 start cleared by disable", eng_valid, 0);
        clrf(6'h3f);
        tick();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule